// File: doc/BRIEF.md
# Saturating Up/Down Wiper Controller

This block keeps the tap position of a 64-step resistor ladder. Software or a host device sees three slow pins: an active-low select, a step clock and a direction line. The block samples all three with a fast system clock and passes each through a synchronizer. On every falling edge of the step clock, while the select is low, it moves a 6-bit wiper code by one position. The code starts at mid-scale after reset. It stops at either end of the range instead of wrapping round.

Alongside the code, the block drives a registered one-hot tap-select bus for the switch array and two end-of-range flags. All of these outputs change in the same system cycle as the code. A step clock that is already low when reset ends cannot cause a step. The first step after reset needs a real high-to-low transition of that pin.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: While and after synchronous reset (rst high), code is 32, tap_sel has only bit 32 set, and at_max and at_min are both 0.
- R2: A falling edge on step_clk_pin with cs_n_pin low and dir_pin high (1) raises code by exactly one.
- R3: A falling edge on step_clk_pin with cs_n_pin low and dir_pin low (0) lowers code by exactly one.
- R4: With cs_n_pin high, edges on step_clk_pin leave code unchanged.
- R5: A rising edge on step_clk_pin never changes code.
- R6: At code 63, further up-steps leave code at 63 (no wrap to 0).
- R7: At code 0, further down-steps leave code at 0 (no wrap to 63).
- R8: tap_sel has exactly one bit set, at the index equal to code, and it changes in the same cycle as code.
- R9: at_max is 1 exactly when code is 63, and at_min is 1 exactly when code is 0.
- R10: When step_clk_pin falls just before a system clock rising edge, code takes its new value on the third rising edge, counting that edge as the first, and keeps its old value on the first two.
- R11: If step_clk_pin is held low through reset and after it, no step occurs. The next step needs the pin to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Asynchronous active-low select; steps are allowed only while it is low |
| step_clk_pin | input | 1 | Asynchronous step clock; steps on its falling edge |
| dir_pin | input | 1 | Asynchronous direction: 1 counts up, 0 counts down |
| code | output | 6 | Current wiper code, 0 to 63 |
| tap_sel | output | 64 | One-hot tap select, bit index equal to code |
| at_max | output | 1 | High when code is 63 |
| at_min | output | 1 | High when code is 0 |

## Verification
A wrong step count or a missed saturation shows at code within three system cycles of the step-clock edge, and then stays wrong until the next reset. A decoder or flag register that falls out of step with the counter shows at once. Either tap_sel stops matching code, or a flag disagrees with the end codes, on the very cycle code moves. Stale edge-detect history is exposed only by the first step after reset. The bench therefore drives a step clock held low across reset and confirms that code stays at 32.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } step_dir_e;

   typedef struct packed {
      logic cs_n;
      logic stclk;
      logic dir;
   } pin_bundle_t;

   // Reset value of the synchronizer chain. The step clock starts low so that
   // a pin held low through reset cannot look like a falling edge.
   localparam pin_bundle_t PIN_RESET = '{cs_n: 1'b1, stclk: 1'b0, dir: 1'b0};

endpackage

// File: rtl/wiper_pin_sync.sv
`timescale 1ns/1ps
module wiper_pin_sync #(
   parameter int               WIDTH     = 3,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      assert (STAGES >= 2) else $error("wiper_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= RESET_VAL;
               else     stg[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= RESET_VAL;
               else     stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/wiper_step_detect.sv
`timescale 1ns/1ps
module wiper_step_detect (
   input  logic clk,
   input  logic rst,
   input  logic stclk_s,
   input  logic cs_n_s,
   input  logic dir_s,
   output logic step_req,
   output logic step_up
);
   import wiper_pkg::*;

   logic prev_q;
   logic armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= stclk_s;
         armed_q <= armed_q | stclk_s;
      end
   end

   assign step_req = armed_q & prev_q & ~stclk_s & ~cs_n_s;
   assign step_up  = (step_dir_e'(dir_s) == DIR_UP);

   // R2: one falling edge yields one step request only
   p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
      step_req |=> !step_req);

   // R5: no request while the synchronized step clock is high
   p_rise_no_step_r5: assert property (@(posedge clk) disable iff (rst)
      stclk_s |-> !step_req);

endmodule

// File: rtl/wiper_sat_counter.sv
`timescale 1ns/1ps
module wiper_sat_counter #(
   parameter int CODE_W     = 6,
   parameter int RESET_CODE = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_req,
   input  logic              step_up,
   output logic [CODE_W-1:0] code_d,
   output logic [CODE_W-1:0] code_q
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MIN = '0;
   localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

   always_comb begin
      code_d = code_q;
      if (step_req) begin
         if (step_up && code_q != CODE_MAX)       code_d = code_q + CODE_W'(1);
         else if (!step_up && code_q != CODE_MIN) code_d = code_q - CODE_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) code_q <= CODE_RST;
      else     code_q <= code_d;
   end

   p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
      (step_req && step_up && code_q != CODE_MAX) |=> code_q == $past(code_q) + CODE_W'(1));

   p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
      (step_req && !step_up && code_q != CODE_MIN) |=> code_q == $past(code_q) - CODE_W'(1));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !step_req |=> $stable(code_q));

   p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (rst)
      (code_q == CODE_MAX && step_up) |=> code_q == CODE_MAX);

   p_no_wrap_bottom_r7: assert property (@(posedge clk) disable iff (rst)
      (code_q == CODE_MIN && !step_up) |=> code_q == CODE_MIN);

endmodule

// File: rtl/wiper_tap_decode.sv
`timescale 1ns/1ps
module wiper_tap_decode #(
   parameter int CODE_W     = 6,
   parameter int RESET_CODE = 32
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [CODE_W-1:0]        code_d,
   output logic [(1<<CODE_W)-1:0]   tap_q,
   output logic                     at_max_q,
   output logic                     at_min_q
);

   localparam int TAPS = 1 << CODE_W;
   localparam logic [TAPS-1:0] TAP_RST = TAPS'(1) << RESET_CODE;

   logic [TAPS-1:0] tap_d;

   genvar i;
   generate
      for (i = 0; i < TAPS; i++) begin : g_tap
         assign tap_d[i] = (code_d == CODE_W'(i));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         tap_q    <= TAP_RST;
         at_max_q <= (RESET_CODE == TAPS - 1);
         at_min_q <= (RESET_CODE == 0);
      end else begin
         tap_q    <= tap_d;
         at_max_q <= tap_d[TAPS-1];
         at_min_q <= tap_d[0];
      end
   end

   p_tap_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_q) == 1);

endmodule

// File: rtl/updown_wiper_ctrl.sv
`timescale 1ns/1ps
module updown_wiper_ctrl #(
   parameter int CODE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cs_n_pin,
   input  logic                   step_clk_pin,
   input  logic                   dir_pin,
   output logic [CODE_W-1:0]      code,
   output logic [(1<<CODE_W)-1:0] tap_sel,
   output logic                   at_max,
   output logic                   at_min
);
   import wiper_pkg::*;

   localparam int MID_CODE = 1 << (CODE_W - 1);
   localparam int PIN_W    = $bits(pin_bundle_t);

   initial begin
      assert (CODE_W >= 2 && CODE_W <= 10) else $error("updown_wiper_ctrl: CODE_W out of range");
   end

   pin_bundle_t pins_a, pins_s;
   logic        step_req, step_up;
   logic [CODE_W-1:0] code_d;

   assign pins_a = '{cs_n: cs_n_pin, stclk: step_clk_pin, dir: dir_pin};

   wiper_pin_sync #(
      .WIDTH    (PIN_W),
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(PIN_RESET)
   ) sync_i (
      .clk    (clk),
      .rst    (rst),
      .d_async(pins_a),
      .q_sync (pins_s)
   );

   wiper_step_detect edge_i (
      .clk     (clk),
      .rst     (rst),
      .stclk_s (pins_s.stclk),
      .cs_n_s  (pins_s.cs_n),
      .dir_s   (pins_s.dir),
      .step_req(step_req),
      .step_up (step_up)
   );

   wiper_sat_counter #(
      .CODE_W    (CODE_W),
      .RESET_CODE(MID_CODE)
   ) cnt_i (
      .clk     (clk),
      .rst     (rst),
      .step_req(step_req),
      .step_up (step_up),
      .code_d  (code_d),
      .code_q  (code)
   );

   wiper_tap_decode #(
      .CODE_W    (CODE_W),
      .RESET_CODE(MID_CODE)
   ) dec_i (
      .clk     (clk),
      .rst     (rst),
      .code_d  (code_d),
      .tap_q   (tap_sel),
      .at_max_q(at_max),
      .at_min_q(at_min)
   );

   p_tap_at_code_r8: assert property (@(posedge clk) disable iff (rst)
      tap_sel[code]);

   p_flag_max_r9: assert property (@(posedge clk) disable iff (rst)
      at_max == (code == {CODE_W{1'b1}}));

   p_flag_min_r9: assert property (@(posedge clk) disable iff (rst)
      at_min == (code == '0));

   p_reset_mid_r1: assert property (@(posedge clk)
      $past(rst) |-> code == CODE_W'(MID_CODE));

endmodule

// File: tb/updown_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module updown_wiper_ctrl_tb_top;

   typedef struct {
      logic [5:0] code;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n_pin = 1'b1;
   logic        step_clk_pin = 1'b1;
   logic        dir_pin = 1'b0;
   logic [5:0]  code;
   logic [63:0] tap_sel;
   logic        at_max, at_min;

   int   n_checks = 0;
   int   n_fail   = 0;
   int   model    = 32;
   exp_t sb_q[$];
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   updown_wiper_ctrl dut_i (
      .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .step_clk_pin(step_clk_pin),
      .dir_pin(dir_pin), .code(code), .tap_sel(tap_sel), .at_max(at_max), .at_min(at_min)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops expected items and compares all outputs
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.req, " code"},   64'(code),   64'(e.code));
            check({e.req, " tap"},    tap_sel,     64'd1 << e.code);
            check({e.req, " at_max"}, 64'(at_max), 64'(e.code == 6'd63));
            check({e.req, " at_min"}, 64'(at_min), 64'(e.code == 6'd0));
         end
      end
   end

   task automatic expect_now(input string req);
      @(posedge clk);
      sb_q.push_back('{code: 6'(model), req: req});
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input logic up, input logic csn, input string req);
      @(negedge clk);
      dir_pin  = up;
      cs_n_pin = csn;
      repeat (3) @(negedge clk);
      step_clk_pin = 1'b0;
      repeat (5) @(negedge clk);
      step_clk_pin = 1'b1;
      repeat (5) @(negedge clk);
      if (!csn) begin
         if (up && model < 63)       model++;
         else if (!up && model > 0)  model--;
      end
      expect_now(req);
   endtask

   initial begin
      #(1ms);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      expect_now("R1 in reset");
      rst = 1'b0;
      repeat (6) @(negedge clk);
      expect_now("R1 after reset");

      for (int k = 0; k < 5; k++) pulse(1'b1, 1'b0, "R2 up");
      for (int k = 0; k < 3; k++) pulse(1'b0, 1'b0, "R3 down");
      for (int k = 0; k < 3; k++) pulse(1'b1, 1'b1, "R4 deselected up");
      for (int k = 0; k < 2; k++) pulse(1'b0, 1'b1, "R4 deselected down");

      // R5: the falling edge steps, the following rising edge does not
      @(negedge clk);
      dir_pin = 1'b1; cs_n_pin = 1'b0;
      repeat (3) @(negedge clk);
      step_clk_pin = 1'b0;
      repeat (6) @(negedge clk);
      model++;
      expect_now("R5 after fall");
      step_clk_pin = 1'b1;
      repeat (6) @(negedge clk);
      expect_now("R5 after rise");

      for (int k = 0; k < 32; k++) pulse(1'b1, 1'b0, "R6 R8 R9 up run");
      expect_now("R6 R9 at top");
      for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, "R6 saturate top");
      for (int k = 0; k < 66; k++) pulse(1'b0, 1'b0, "R7 R8 R9 down run");
      pulse(1'b0, 1'b0, "R7 saturate bottom");

      // R10: latency from pin edge to code, counted in system clock edges
      @(negedge clk);
      dir_pin = 1'b1; cs_n_pin = 1'b0;
      repeat (3) @(negedge clk);
      step_clk_pin = 1'b0;
      @(posedge clk); #1;
      check("R10 edge1", 64'(code), 64'(model));
      @(posedge clk); #1;
      check("R10 edge2", 64'(code), 64'(model));
      @(posedge clk); #1;
      model++;
      check("R10 edge3", 64'(code), 64'(model));
      check("R10 R8 tap edge3", tap_sel, 64'd1 << model);
      @(negedge clk);
      step_clk_pin = 1'b1;
      repeat (5) @(negedge clk);

      // R11: step clock held low through reset gives no step
      step_clk_pin = 1'b0; cs_n_pin = 1'b0; dir_pin = 1'b1;
      rst = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      model = 32;
      repeat (10) @(negedge clk);
      expect_now("R11 no spurious step");
      step_clk_pin = 1'b1;
      repeat (5) @(negedge clk);
      step_clk_pin = 1'b0;
      repeat (6) @(negedge clk);
      model = 33;
      expect_now("R11 first real step");
      step_clk_pin = 1'b1;
      repeat (5) @(negedge clk);

      repeat (4) @(negedge clk);
      check("scoreboard drained", 64'(sb_q.size()), 64'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule